// File: doc/BRIEF.md
# Programmable Logic Cell with Edge-Delay Filters

This block is one general-purpose logic cell. Four logic inputs are each picked from a pool of candidate signals by a source multiplexer: a constant low, one of the external inputs, or one of the logic outputs fed back from neighbouring cells. The four picked bits form a 4-bit index into a 16-bit lookup table, one table per output. Each output can therefore apply its own Boolean function of the same four inputs.

Each output then passes through a filter with two separate delays, one for rising transitions and one for falling transitions, both counted in core clocks. A change at the table result that reverts before its delay has run out is dropped. The cell can therefore act as a glitch filter, as a pulse stretcher or shrinker, or as a delayed copy of a signal. After the filter, an invert bit may flip the level, and an enable input forces the output low while it is cleared. All configuration is loaded through a single-cycle register-write port.

Top module: `edge_filter_logic_cell`

## Requirements
- R1: Each output's table result is bit `lut[{s3,s2,s1,s0}]` of its 16-bit table word, where `s_k` is the source selected for logic input k (input 0 is the least significant index bit).
- R2: With the table result held, a 0-to-1 change reaches the output `rise+1` clocks after the result changes, and a 1-to-0 change takes `fall+1` clocks. The change is counted from the first clock edge that sees the new result.
- R3: A table-result change that reverts before its delay has elapsed is discarded, and the output keeps its previous level.
- R4: While an output's enable bit is 0, that output is 0 from the next clock on. When the bit is set, the filtered level appears on the next clock.
- R5: After reset, every table word, every rise and fall delay, and every invert bit is 0, every source select is code 0, and all outputs are 0.
- R6: Source select codes are as follows. Code 0 gives constant 0. Codes 1 to 12 give external inputs 0 to 11. Codes 13 to 24 give feedback inputs 0 to 11. Codes 25 to 31 give constant 0.
- R7: A delay value of 0 lets a transition reach the output on the clock edge that first sees it.
- R8: The invert bit is applied after the filter and only to an enabled output: output = enable & (filtered level XOR invert).
- R9: A write takes effect in the clock after the write edge. The address is decoded as follows: `addr[3:2]` picks the group and `addr[1:0]` picks the index. Group 0 is the source select (`wdata[4:0]`). Group 1 is the table word (`wdata[15:0]`). Group 2 holds the delays, rise in `wdata[7:0]` and fall in `wdata[15:8]`. Group 3 is the invert bit (`wdata[0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_in | input | N_EXT (12) | External candidate inputs, select codes 1 to 12 |
| lo_in | input | N_LO (12) | Feedback candidate inputs from cell outputs, select codes 13 to 24 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address: group in [3:2], index in [1:0] |
| cfg_wdata | input | 16 | Configuration write data |
| out_en | input | N_OUT (4) | Per-output enable |
| lc_out | output | N_OUT (4) | Filtered, optionally inverted, registered outputs |

## Verification
The hardest situation to reach is a transition that is abandoned part-way through its delay. The table result must go back to the old level after some clocks of counting, but fewer than the delay needs. A pulse whose length is one clock short of the delay must still vanish. The stimulus sets a long rise delay and a shorter fall delay on a cell wired as a copy of one external input. It then applies pulses of chosen lengths in both directions and counts clock edges to the exact cycle where the output must or must not move. After that comes a long stretch of random inputs, random enables and random writes, with small delays so that some filters commit and others abandon, all compared on every clock with the bench's model.

// File: rtl/elc_pkg.sv
package elc_pkg;
  localparam int LUT_IN = 4;
  localparam int LUT_W  = 1 << LUT_IN;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 16;
  localparam int IDX_W  = 2;

  typedef enum logic [1:0] {
    GRP_SRC  = 2'd0,
    GRP_LUT  = 2'd1,
    GRP_DLY  = 2'd2,
    GRP_INV  = 2'd3
  } cfg_group_e;
endpackage

// File: rtl/elc_cfg_regs.sv
module elc_cfg_regs
  import elc_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int SEL_W  = 5,
  parameter int FILT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [CFG_AW-1:0]         addr,
  input  logic [CFG_DW-1:0]         wdata,
  output logic [LUT_IN*SEL_W-1:0]   sel_flat,
  output logic [N_OUT*LUT_W-1:0]    lut_flat,
  output logic [N_OUT*FILT_W-1:0]   rise_flat,
  output logic [N_OUT*FILT_W-1:0]   fall_flat,
  output logic [N_OUT-1:0]          inv_vec
);
  cfg_group_e       grp;
  logic [IDX_W-1:0] idx;

  assign grp = cfg_group_e'(addr[CFG_AW-1:IDX_W]);
  assign idx = addr[IDX_W-1:0];

  for (genvar k = 0; k < LUT_IN; k++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)
        sel_flat[k*SEL_W +: SEL_W] <= '0;
      else if (we && grp == GRP_SRC && idx == IDX_W'(k))
        sel_flat[k*SEL_W +: SEL_W] <= wdata[SEL_W-1:0];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        lut_flat[o*LUT_W +: LUT_W]    <= '0;
        rise_flat[o*FILT_W +: FILT_W] <= '0;
        fall_flat[o*FILT_W +: FILT_W] <= '0;
        inv_vec[o]                    <= 1'b0;
      end else if (we && idx == IDX_W'(o)) begin
        case (grp)
          GRP_LUT: lut_flat[o*LUT_W +: LUT_W] <= wdata[LUT_W-1:0];
          GRP_DLY: begin
            rise_flat[o*FILT_W +: FILT_W] <= wdata[FILT_W-1:0];
            fall_flat[o*FILT_W +: FILT_W] <= wdata[2*FILT_W-1:FILT_W];
          end
          GRP_INV: inv_vec[o] <= wdata[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/elc_src_mux.sv
module elc_src_mux #(
  parameter int N_EXT = 12,
  parameter int N_LO  = 12,
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_EXT-1:0] ext,
  input  logic [N_LO-1:0]  lo,
  output logic             y
);
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N_EXT; i++)
      if (sel == SEL_W'(i + 1)) y = ext[i];
    for (int i = 0; i < N_LO; i++)
      if (sel == SEL_W'(i + 1 + N_EXT)) y = lo[i];
  end
endmodule

// File: rtl/elc_out_path.sv
module elc_out_path
  import elc_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LUT_W-1:0]  lut,
  input  logic [LUT_IN-1:0] lut_idx,
  input  logic [FILT_W-1:0] rise,
  input  logic [FILT_W-1:0] fall,
  input  logic              en,
  input  logic              inv,
  output logic              lut_v,
  output logic              lvl,
  output logic              q
);
  logic [FILT_W-1:0] cnt;
  logic [FILT_W-1:0] dly;
  logic              pending;
  logic              commit;
  logic              lvl_nxt;

  assign lut_v   = lut[lut_idx];
  assign pending = (lut_v != lvl);
  assign dly     = lut_v ? rise : fall;
  assign commit  = pending && (cnt >= dly);
  assign lvl_nxt = commit ? lut_v : lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0;
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      lvl <= lvl_nxt;
      cnt <= (!pending || commit) ? '0 : cnt + FILT_W'(1);
      q   <= en & (lvl_nxt ^ inv);
    end
  end
endmodule

// File: rtl/edge_filter_logic_cell.sv
module edge_filter_logic_cell
  import elc_pkg::*;
#(
  parameter int N_EXT  = 12,
  parameter int N_LO   = 12,
  parameter int N_OUT  = 4,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_in,
  input  logic [N_LO-1:0]   lo_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [N_OUT-1:0]  out_en,
  output logic [N_OUT-1:0]  lc_out
);
  localparam int SEL_W = $clog2(N_EXT + N_LO + 1);

  logic [LUT_IN*SEL_W-1:0] sel_flat;
  logic [N_OUT*LUT_W-1:0]  lut_flat;
  logic [N_OUT*FILT_W-1:0] rise_flat;
  logic [N_OUT*FILT_W-1:0] fall_flat;
  logic [N_OUT-1:0]        inv_vec;
  logic [LUT_IN-1:0]       lut_idx;
  logic [N_OUT-1:0]        lutv_vec;
  logic [N_OUT-1:0]        lvl_vec;

  elc_cfg_regs #(.N_OUT(N_OUT), .SEL_W(SEL_W), .FILT_W(FILT_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel_flat(sel_flat), .lut_flat(lut_flat), .rise_flat(rise_flat),
    .fall_flat(fall_flat), .inv_vec(inv_vec)
  );

  for (genvar k = 0; k < LUT_IN; k++) begin : g_mux
    elc_src_mux #(.N_EXT(N_EXT), .N_LO(N_LO), .SEL_W(SEL_W)) u_mux (
      .sel(sel_flat[k*SEL_W +: SEL_W]), .ext(ext_in), .lo(lo_in), .y(lut_idx[k])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_path
    elc_out_path #(.FILT_W(FILT_W)) u_path (
      .clk(clk), .rst(rst),
      .lut(lut_flat[o*LUT_W +: LUT_W]), .lut_idx(lut_idx),
      .rise(rise_flat[o*FILT_W +: FILT_W]), .fall(fall_flat[o*FILT_W +: FILT_W]),
      .en(out_en[o]), .inv(inv_vec[o]),
      .lut_v(lutv_vec[o]), .lvl(lvl_vec[o]), .q(lc_out[o])
    );
  end
endmodule

// File: rtl/elc_checker.sv
module elc_checker #(
  parameter int N_OUT  = 4,
  parameter int FILT_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_OUT-1:0]          out_en,
  input logic [N_OUT-1:0]          lc_out,
  input logic [N_OUT-1:0]          lutv_vec,
  input logic [N_OUT-1:0]          lvl_vec,
  input logic [N_OUT-1:0]          inv_vec,
  input logic [N_OUT*FILT_W-1:0]   rise_flat,
  input logic [N_OUT*FILT_W-1:0]   fall_flat
);
  AST_RESET_CLEARS_OUT: assert property (@(posedge clk) rst |=> (lc_out == '0)); // R5

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    AST_DISABLED_IS_LOW: assert property (@(posedge clk) disable iff (rst)
      !out_en[o] |=> !lc_out[o]); // R4

    AST_LEVEL_FOLLOWS_LUT: assert property (@(posedge clk) disable iff (rst)
      (lvl_vec[o] != $past(lvl_vec[o])) |-> (lvl_vec[o] == $past(lutv_vec[o]))); // R3

    AST_ZERO_DELAY_PASS: assert property (@(posedge clk) disable iff (rst)
      ((rise_flat[o*FILT_W +: FILT_W] == '0) && (fall_flat[o*FILT_W +: FILT_W] == '0)
       && (lutv_vec[o] != lvl_vec[o])) |=> (lvl_vec[o] == $past(lutv_vec[o]))); // R7

    AST_INVERT_AFTER_FILTER: assert property (@(posedge clk) disable iff (rst)
      out_en[o] |=> (lc_out[o] == (lvl_vec[o] ^ $past(inv_vec[o])))); // R8
  end
endmodule

bind edge_filter_logic_cell elc_checker #(.N_OUT(N_OUT), .FILT_W(FILT_W)) u_chk (
  .clk(clk), .rst(rst), .out_en(out_en), .lc_out(lc_out), .lutv_vec(lutv_vec),
  .lvl_vec(lvl_vec), .inv_vec(inv_vec), .rise_flat(rise_flat), .fall_flat(fall_flat)
);

// File: tb/edge_filter_logic_cell_tb.sv
`timescale 1ns/1ps
module edge_filter_logic_cell_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ext_in = '0;
  logic [11:0] lo_in = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  out_en = '0;
  logic [3:0]  lc_out;

  int n_chk = 0;
  int n_err = 0;
  string phase = "R5 reset";
  bit started = 1'b0;

  // reference model state
  int        m_sel [4];
  bit [15:0] m_lut [4];
  int        m_rise[4];
  int        m_fall[4];
  bit        m_inv [4];
  bit        m_lvl [4];
  int        m_cnt [4];
  bit        m_out [4];

  always #2.5 clk = ~clk;

  edge_filter_logic_cell u_dut (
    .clk(clk), .rst(rst), .ext_in(ext_in), .lo_in(lo_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_en(out_en), .lc_out(lc_out)
  );

  function automatic bit src_of(int code);
    if (code >= 1 && code <= 12) return ext_in[code-1];
    if (code >= 13 && code <= 24) return lo_in[code-13];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < 4; o++) begin
        m_sel[o] = 0; m_lut[o] = '0; m_rise[o] = 0; m_fall[o] = 0;
        m_inv[o] = 0; m_lvl[o] = 0; m_cnt[o] = 0; m_out[o] = 0;
      end
    end else begin
      int idx;
      idx = 0;
      for (int k = 0; k < 4; k++) idx = idx | (int'(src_of(m_sel[k])) << k);
      for (int o = 0; o < 4; o++) begin
        bit v;
        v = m_lut[o][idx];
        if (v == m_lvl[o]) m_cnt[o] = 0;
        else if (m_cnt[o] >= (v ? m_rise[o] : m_fall[o])) begin
          m_lvl[o] = v; m_cnt[o] = 0;
        end else m_cnt[o]++;
        m_out[o] = out_en[o] & (m_lvl[o] ^ m_inv[o]);
      end
      if (cfg_we) begin
        int i;
        i = int'(cfg_addr[1:0]);
        case (cfg_addr[3:2])
          2'd0: m_sel[i] = int'(cfg_wdata[4:0]);
          2'd1: m_lut[i] = cfg_wdata;
          2'd2: begin m_rise[i] = int'(cfg_wdata[7:0]); m_fall[i] = int'(cfg_wdata[15:8]); end
          default: m_inv[i] = cfg_wdata[0];
        endcase
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      for (int o = 0; o < 4; o++) begin
        n_chk++;
        if (lc_out[o] !== m_out[o]) begin
          n_err++;
          $display("FAIL %s model out%0d actual=%0b expected=%0b", phase, o, lc_out[o], m_out[o]);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    out_en = 4'hF;
    // R5: nothing configured, outputs stay low while inputs move
    phase = "R5 reset";
    for (int t = 0; t < 6; t++) begin
      ext_in = 12'hFFF ^ 12'(t); lo_in = 12'hFFF;
      step(1);
      chk(lc_out == 4'h0, "R5 outputs after reset", lc_out, 0);
    end
    ext_in = '0; lo_in = '0;

    // R1 / R9: table lookup with the four inputs on ext 0..3
    phase = "R1 table";
    for (int k = 0; k < 4; k++) wr(k, k + 1);
    wr(4, 16'h6996); wr(5, 16'h8000); wr(6, 16'hFFFE); wr(7, 16'h1234);
    step(2);
    for (int p = 0; p < 16; p++) begin
      bit [15:0] arb;
      arb = 16'h1234;
      ext_in[3:0] = 4'(p);
      step(1);
      chk(lc_out[0] == ^4'(p), "R1 xor table", lc_out[0], ^4'(p));
      chk(lc_out[1] == (p == 15), "R1 and table", lc_out[1], int'(p == 15));
      chk(lc_out[2] == (p != 0), "R1 or table", lc_out[2], int'(p != 0));
      chk(lc_out[3] == arb[p], "R1 mixed table", lc_out[3], arb[p]);
    end

    // R2: out0 copies input 0, rise 5, fall 2
    phase = "R2 delays";
    ext_in = '0;
    wr(4, 16'hAAAA); wr(8, 16'h0205);
    step(10);
    ext_in[0] = 1'b1;
    step(5);
    chk(lc_out[0] == 1'b0, "R2 rise not before 6 clocks", lc_out[0], 0);
    step(1);
    chk(lc_out[0] == 1'b1, "R2 rise at 6 clocks", lc_out[0], 1);
    step(4);
    ext_in[0] = 1'b0;
    step(2);
    chk(lc_out[0] == 1'b1, "R2 fall not before 3 clocks", lc_out[0], 1);
    step(1);
    chk(lc_out[0] == 1'b0, "R2 fall at 3 clocks", lc_out[0], 0);

    // R3: pulses one clock too short are dropped
    phase = "R3 glitch";
    step(4);
    ext_in[0] = 1'b1;
    step(5);
    ext_in[0] = 1'b0;
    for (int t = 0; t < 8; t++) begin
      step(1);
      chk(lc_out[0] == 1'b0, "R3 short high pulse dropped", lc_out[0], 0);
    end
    ext_in[0] = 1'b1;
    step(12);
    chk(lc_out[0] == 1'b1, "R3 long high pulse kept", lc_out[0], 1);
    ext_in[0] = 1'b0;
    step(2);
    ext_in[0] = 1'b1;
    for (int t = 0; t < 6; t++) begin
      step(1);
      chk(lc_out[0] == 1'b1, "R3 short low pulse dropped", lc_out[0], 1);
    end

    // R7: out1 copies input 0 with zero delays
    phase = "R7 zero delay";
    wr(5, 16'hAAAA); wr(9, 0);
    step(2);
    ext_in[0] = 1'b0;
    step(1);
    chk(lc_out[1] == 1'b0, "R7 fall on next clock", lc_out[1], 0);
    ext_in[0] = 1'b1;
    step(1);
    chk(lc_out[1] == 1'b1, "R7 rise on next clock", lc_out[1], 1);

    // R9: write timing on out2 (zero delays)
    phase = "R9 write timing";
    wr(10, 0); wr(6, 16'h0000);
    step(3);
    wr(6, 16'hFFFF);
    chk(lc_out[2] == 1'b0, "R9 old table on write edge", lc_out[2], 0);
    step(1);
    chk(lc_out[2] == 1'b1, "R9 new table one clock later", lc_out[2], 1);

    // R4: enable gating
    phase = "R4 enable";
    out_en[2] = 1'b0;
    step(1);
    chk(lc_out[2] == 1'b0, "R4 disabled output low", lc_out[2], 0);
    step(3);
    chk(lc_out[2] == 1'b0, "R4 stays low while disabled", lc_out[2], 0);
    out_en[2] = 1'b1;
    step(1);
    chk(lc_out[2] == 1'b1, "R4 re-enabled output", lc_out[2], 1);

    // R8: invert after filter, gated by enable
    phase = "R8 invert";
    wr(14, 1);
    chk(lc_out[2] == 1'b1, "R8 invert not yet applied", lc_out[2], 1);
    step(1);
    chk(lc_out[2] == 1'b0, "R8 inverted level", lc_out[2], 0);
    wr(6, 16'h0000);
    step(1);
    chk(lc_out[2] == 1'b1, "R8 inverted low table", lc_out[2], 1);
    out_en[2] = 1'b0;
    step(1);
    chk(lc_out[2] == 1'b0, "R8 disabled beats invert", lc_out[2], 0);
    out_en[2] = 1'b1;
    wr(14, 0);

    // R6: select codes, out3 copies input 0 with zero delays
    phase = "R6 select";
    wr(7, 16'hAAAA); wr(11, 0);
    wr(0, 18);
    lo_in = '0; ext_in = 12'hFFF;
    step(2);
    chk(lc_out[3] == 1'b0, "R6 code 18 low", lc_out[3], 0);
    lo_in[5] = 1'b1;
    step(1);
    chk(lc_out[3] == 1'b1, "R6 code 18 picks feedback 5", lc_out[3], 1);
    wr(0, 12);
    ext_in = 12'h7FF;
    step(1);
    chk(lc_out[3] == 1'b0, "R6 code 12 picks ext 11 low", lc_out[3], 0);
    ext_in[11] = 1'b1;
    step(1);
    chk(lc_out[3] == 1'b1, "R6 code 12 picks ext 11 high", lc_out[3], 1);
    wr(0, 25);
    lo_in = 12'hFFF;
    step(2);
    chk(lc_out[3] == 1'b0, "R6 code 25 constant low", lc_out[3], 0);
    wr(0, 0);
    step(2);
    chk(lc_out[3] == 1'b0, "R6 code 0 constant low", lc_out[3], 0);

    // mixed random traffic, compared each clock against the model
    phase = "random mix of R2 R3 R6";
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) ext_in = 12'($urandom);
      if ($urandom % 4 == 0) lo_in = 12'($urandom);
      if ($urandom % 16 == 0) out_en = 4'($urandom);
      cfg_we = ($urandom % 8 == 0);
      cfg_addr = 4'($urandom);
      cfg_wdata = 16'($urandom);
      if (cfg_addr[3:2] == 2'd2) cfg_wdata = cfg_wdata & 16'h0707;
    end
    cfg_we = 1'b0;
    step(2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule